// File: doc/BRIEF.md
# Syndrome-Match Single-Bit Corrector

This block is a fast read-path decoder for a 144-bit word protected by a two-symbol Reed-Solomon code over GF(2^8). It does not attempt symbol correction. Instead it gets single-bit correction and double-bit detection out of the same check symbols. It forms a 16-bit binary syndrome from the incoming word. Each of the 144 bit positions then compares that syndrome against its own constant pattern, and the data bit whose pattern matches is inverted. A nonzero syndrome that no position claims is reported as an uncorrectable multi-bit error.

The word arrives with a valid strobe. The syndrome, the comparators and the correction form one combinational stage. A single output register follows it, so each result appears one clock after its input. A slower symbol-level decoder elsewhere in the system can still act on words flagged here.

Top module: `syn_match_corrector`

## Requirements
- R1: The input word holds eighteen 8-bit symbols, with symbol j in bits [8j+7:8j]. Symbols 0 to 15 are data and form `data_o` in the same bit order. Symbols 16 and 17 are check symbols.
- R2: The syndrome has two bytes. The low byte is the XOR of all eighteen symbols. The high byte is the XOR over j of alpha^j times symbol j, where alpha = 0x02 in GF(2^8) with reduction polynomial 0x11D. A word with a zero syndrome leaves data unchanged and raises neither flag.
- R3: Suppose exactly one bit among bits 0 to 127 of a valid codeword is flipped. The output data equals the original data, `corr_o` is 1 and `det_o` is 0. At most one position's comparator matches any syndrome.
- R4: Suppose exactly one bit among bits 128 to 143 is flipped. The output data equals the received data bits, `corr_o` is 1 and `det_o` is 0.
- R5: Suppose exactly two distinct bits of a valid codeword are flipped, in any positions. `det_o` is 1 and `corr_o` is 0, and the output data equals the received bits 0 to 127 with nothing inverted.
- R6: `corr_o` and `det_o` are never 1 in the same cycle.
- R7: A word presented with `valid_i` high at a rising edge produces its result at the next rising edge, and `valid_o` is 1 for exactly that cycle. `valid_o` is 0 in every other cycle.
- R8: After an edge where `valid_i` is 0, `corr_o` and `det_o` are 0 and `data_o` keeps its previous value, whatever the word input carries.
- R9: While `rst_n` is 0, `valid_o`, `corr_o`, `det_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Word input carries a word to decode |
| cw_i | input | 144 | Received word: 16 data symbols then 2 check symbols |
| valid_o | output | 1 | Output fields hold a fresh result |
| data_o | output | 128 | Corrected data |
| corr_o | output | 1 | A single-bit error was found and handled |
| det_o | output | 1 | An uncorrectable multi-bit error was found |

## Verification
Every result (data, both flags and `valid_o`) is due exactly one rising edge after its word is accepted. The driver stamps each expected item with the cycle number in which the result must show. The monitor samples on the falling edge. A result counts as a failure if it appears in a cycle where no item is due, or if it is missing in a cycle where one is due. In idle cycles the monitor instead checks that the flags are low and the data has not moved.

// File: rtl/syn_match_corrector.sv
module syn_match_corrector #(
  parameter int SYM_W = 8,
  parameter int DATA_SYMS = 16,
  parameter logic [SYM_W:0] POLY = 9'h11D
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          valid_i,
  input  logic [(DATA_SYMS+2)*SYM_W-1:0] cw_i,
  output logic                          valid_o,
  output logic [DATA_SYMS*SYM_W-1:0]    data_o,
  output logic                          corr_o,
  output logic                          det_o
);
  localparam int SYMS   = DATA_SYMS + 2;
  localparam int CW_W   = SYMS * SYM_W;
  localparam int DATA_W = DATA_SYMS * SYM_W;
  localparam int SYN_W  = 2 * SYM_W;

  function automatic logic [SYM_W-1:0] xt(input logic [SYM_W-1:0] x);
    return {x[SYM_W-2:0], 1'b0} ^ (x[SYM_W-1] ? POLY[SYM_W-1:0] : '0);
  endfunction

  function automatic logic [SYM_W-1:0] mul_ap(input logic [SYM_W-1:0] x, input int j);
    logic [SYM_W-1:0] r;
    r = x;
    for (int k = 0; k < j; k++) r = xt(r);
    return r;
  endfunction

  function automatic logic [SYN_W-1:0] col_syn(input int pos);
    logic [SYM_W-1:0] e;
    e = SYM_W'(1) << (pos % SYM_W);
    return {mul_ap(e, pos / SYM_W), e};
  endfunction

  logic [SYM_W-1:0] s_lo, s_hi;
  logic [SYN_W-1:0] syn;
  logic [CW_W-1:0]  match;
  logic             corr_n, det_n;

  always_comb begin
    s_lo = '0;
    s_hi = '0;
    for (int j = 0; j < SYMS; j++) begin
      s_lo = s_lo ^ cw_i[j*SYM_W +: SYM_W];
      s_hi = s_hi ^ mul_ap(cw_i[j*SYM_W +: SYM_W], j);
    end
  end

  assign syn = {s_hi, s_lo};

  for (genvar i = 0; i < CW_W; i++) begin : g_cmp
    localparam logic [SYN_W-1:0] PAT = col_syn(i);
    assign match[i] = (syn == PAT);
  end

  assign corr_n = |match;
  assign det_n  = (syn != '0) && !corr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      corr_o  <= 1'b0;
      det_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      corr_o  <= valid_i && corr_n;
      det_o   <= valid_i && det_n;
      if (valid_i) data_o <= cw_i[DATA_W-1:0] ^ match[DATA_W-1:0];
    end
  end

  // R3
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R6
  flag_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(corr_o && det_o));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  // R7
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(data_o) && !corr_o && !det_o));

  // R2
  clean_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && syn == '0) |=> (!corr_o && !det_o && data_o == $past(cw_i[DATA_W-1:0])));
endmodule

// File: tb/tb_syn_match_corrector.sv
module tb_syn_match_corrector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [143:0] cw_i = '0;
  logic         valid_o;
  logic [127:0] data_o;
  logic         corr_o, det_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [127:0] d;
    logic         c;
    logic         e;
    int           due;
    string        tag;
  } item_t;
  item_t sb[$];

  syn_match_corrector dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cw_i(cw_i),
    .valid_o(valid_o), .data_o(data_o), .corr_o(corr_o), .det_o(det_o)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] gmul2(input logic [7:0] x);
    return x[7] ? ((x << 1) ^ 8'h1D) : (x << 1);
  endfunction

  function automatic logic [7:0] apow(input logic [7:0] x, input int n);
    logic [7:0] r;
    r = x;
    for (int k = 0; k < n; k++) r = gmul2(r);
    return r;
  endfunction

  function automatic logic [143:0] encode(input logic [127:0] d);
    logic [7:0] s0, s1, c17;
    logic [143:0] w;
    s0 = '0;
    s1 = '0;
    for (int j = 0; j < 16; j++) begin
      s0 ^= d[j*8 +: 8];
      s1 ^= apow(d[j*8 +: 8], j);
    end
    w = {16'h0, d};
    for (int c = 0; c < 256; c++) begin
      c17 = s0 ^ 8'(c);
      if ((apow(8'(c), 16) ^ apow(c17, 17)) == s1) begin
        w[135:128] = 8'(c);
        w[143:136] = c17;
      end
    end
    return w;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [143:0] w, input logic [127:0] ed,
                      input logic ec, input logic ee, input string tag);
    item_t it;
    @(negedge clk);
    valid_i = 1'b1;
    cw_i = w;
    it.d = ed; it.c = ec; it.e = ee; it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      cw_i = {$urandom, rnd128()};
    end
  endtask

  // monitor
  initial begin
    logic [127:0] prev;
    item_t it;
    prev = '0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (done) break;
      if (sb.size() != 0 && sb[0].due == cyc) begin
        it = sb.pop_front();
        check(valid_o === 1'b1, "R7", "result missing in due cycle", 128'(valid_o), 128'(1));
        check(data_o === it.d, it.tag, "data", data_o, it.d);
        check(corr_o === it.c, it.tag, "corrected flag", 128'(corr_o), 128'(it.c));
        check(det_o === it.e, it.tag, "detected flag", 128'(det_o), 128'(it.e));
        check(!(corr_o && det_o), "R6", "both flags", {corr_o, det_o}, 128'(0));
      end else begin
        check(valid_o === 1'b0, "R7", "valid out with nothing due", 128'(valid_o), 128'(0));
        check(!corr_o && !det_o, "R8", "flag while idle", {corr_o, det_o}, 128'(0));
        check(data_o === prev, "R8", "data moved while idle", data_o, prev);
      end
      prev = data_o;
    end
  end

  // watchdog
  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] d;
    logic [143:0] w, base;
    int a, b;

    repeat (3) @(negedge clk);
    // R9 reset state
    check(valid_o === 1'b0, "R9", "valid in reset", 128'(valid_o), 128'(0));
    check(data_o === '0, "R9", "data in reset", data_o, 128'(0));
    check(!corr_o && !det_o, "R9", "flags in reset", {corr_o, det_o}, 128'(0));
    rst_n = 1'b1;
    idle(2);

    // R2 / R1 clean words
    send('0, '0, 1'b0, 1'b0, "R2");
    d = {128{1'b1}};
    send(encode(d), d, 1'b0, 1'b0, "R2");
    for (int k = 0; k < 10; k++) begin
      d = rnd128();
      send(encode(d), d, 1'b0, 1'b0, "R1");
    end
    idle(3);

    // R3 / R4 every single-bit position
    d = rnd128();
    base = encode(d);
    for (int i = 0; i < 144; i++) begin
      w = base ^ (144'(1) << i);
      send(w, d, 1'b1, 1'b0, (i < 128) ? "R3" : "R4");
    end
    idle(2);

    // R5 chosen double-bit patterns
    d = rnd128();
    base = encode(d);
    w = base ^ (144'(1) << 0) ^ (144'(1) << 1);
    send(w, w[127:0], 1'b0, 1'b1, "R5");
    w = base ^ (144'(1) << 3) ^ (144'(1) << 43);
    send(w, w[127:0], 1'b0, 1'b1, "R5");
    w = base ^ (144'(1) << 130) ^ (144'(1) << 140);
    send(w, w[127:0], 1'b0, 1'b1, "R5");
    w = base ^ (144'(1) << 5) ^ (144'(1) << 137);
    send(w, w[127:0], 1'b0, 1'b1, "R5");
    w = base ^ (144'(1) << 127) ^ (144'(1) << 128);
    send(w, w[127:0], 1'b0, 1'b1, "R5");
    idle(1);

    // R5 random double-bit patterns
    for (int k = 0; k < 80; k++) begin
      d = rnd128();
      base = encode(d);
      a = $urandom % 144;
      b = $urandom % 144;
      while (b == a) b = $urandom % 144;
      w = base ^ (144'(1) << a) ^ (144'(1) << b);
      send(w, w[127:0], 1'b0, 1'b1, "R5");
      if (k % 7 == 0) idle(1 + k % 3);
    end

    // R7 lone word followed by garbage idle (R8)
    d = rnd128();
    send(encode(d), d, 1'b0, 1'b0, "R7");
    idle(4);

    check(sb.size() == 0, "R7", "results outstanding", 128'(sb.size()), 128'(0));
    done = 1;
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule